// File: doc/BRIEF.md
# SHA-2 Message Schedule Expander

This block advances a SHA-2 message schedule by four words per operation. It receives the sixteen most recent schedule words, packed into three four-word operand groups, and returns the next four words as one packed group. A width select chooses between 32-bit words with the SHA-256 sigma functions and 64-bit words with the SHA-512 sigma functions. One datapath of 64-bit lanes serves both widths. In 32-bit mode the operations run on the low half of each lane.

A hashing engine supplies the groups at the same time as a valid strobe. The result and its valid flag appear on the next clock. The result takes the place of the oldest group in the caller's storage, so the caller must capture all three operands before it writes the result back. Two of the four new words depend on the other two, which gives a two-level adder chain inside the cycle. If the select value is not a legal width, the block raises an error flag and produces no result.

Top module: `sha2_sched_expand`

## Requirements
- R1: While rst_ni is low, valid_o, err_o and res_o are all zero.
- R2: The select sew_i uses 0 for 32-bit words and 1 for 64-bit words. When valid_i is high with sew_i equal to 2 or 3, err_o goes high on the next cycle, valid_o stays low and res_o keeps its previous value.
- R3: Each group holds four slots. Slot k occupies bits [32k+31:32k] in 32-bit mode and bits [64k+63:64k] in 64-bit mode. Slots 3 down to 0 hold W3, W2, W1, W0 in grp_a_i, W11, W10, W9, W4 in grp_b_i, and W15, W14, W13, W12 in grp_c_i.
- R4: The value of W13 (slot 1 of grp_c_i) has no effect on res_o.
- R5: In 32-bit mode each new word is W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32, where s0 = rotr7^rotr18^shr3 and s1 = rotr17^rotr19^shr10.
- R6: In 64-bit mode the same recurrence is computed mod 2^64, with s0 = rotr1^rotr8^shr7 and s1 = rotr19^rotr61^shr6.
- R7: W18 and W19 are computed from the newly produced W16 and W17 (their t-2 term), all within the same operation.
- R8: res_o holds W19 in slot 3, W18 in slot 2, W17 in slot 1 and W16 in slot 0, using the R3 slot positions.
- R9: In 32-bit mode, bits 255:128 of the operand inputs are ignored and bits 255:128 of res_o are zero.
- R10: valid_o is high exactly one cycle after valid_i is high with a legal select. res_o changes only on such a cycle and otherwise holds its value, and err_o is never high together with valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| sew_i | input | 2 | Word width select (0: 32-bit, 1: 64-bit) |
| grp_a_i | input | 256 | Words W3, W2, W1, W0 |
| grp_b_i | input | 256 | Words W11, W10, W9, W4 |
| grp_c_i | input | 256 | Words W15, W14, W13, W12 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| err_o | output | 1 | Illegal width select seen on the previous cycle |
| res_o | output | 256 | Packed W19, W18, W17, W16 |

## Verification
The checker watches every cycle for the timing and control behaviour. It checks the one-cycle relation between the strobe and the valid or error flags, that the two flags never rise together, that the result holds when no legal operation ran, and that the upper half of the result is zero after a 32-bit operation. The arithmetic cannot be checked that way: the sigma rotations, the word mapping, the W16/W17-to-W18/W19 chaining and the slot packing are checked only by the bench's reference recurrence over random 32-bit and 64-bit operands. The same holds for the insensitivity to W13 and to the upper input bits, which the bench shows by repeating an operation with those bits changed.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;
  localparam int LANE_W  = 64;
  localparam int NSLOT   = 4;
  localparam int GRP_W   = LANE_W * NSLOT;
  localparam int HALF_W  = LANE_W / 2;

  typedef enum logic [1:0] {
    SEW_32 = 2'd0,
    SEW_64 = 2'd1
  } sew_e;
endpackage

// File: rtl/sha2_sigma.sv
module sha2_sigma
  import sha2_sched_pkg::*;
#(
  parameter bit SMALL1 = 1'b0  // 0: sigma0, 1: sigma1
) (
  input  logic              is64_i,
  input  logic [LANE_W-1:0] x_i,
  output logic [LANE_W-1:0] y_o
);
  logic [HALF_W-1:0] y32;
  logic [LANE_W-1:0] y64;
  logic [HALF_W-1:0] xl;

  assign xl = x_i[HALF_W-1:0];

  generate
    if (SMALL1) begin : g_s1
      assign y32 = {xl[16:0], xl[31:17]} ^ {xl[18:0], xl[31:19]} ^ (xl >> 10);
      assign y64 = {x_i[18:0], x_i[63:19]} ^ {x_i[60:0], x_i[63:61]} ^ (x_i >> 6);
    end else begin : g_s0
      assign y32 = {xl[6:0], xl[31:7]} ^ {xl[17:0], xl[31:18]} ^ (xl >> 3);
      assign y64 = {x_i[0], x_i[63:1]} ^ {x_i[7:0], x_i[63:8]} ^ (x_i >> 7);
    end
  endgenerate

  assign y_o = is64_i ? y64 : {{HALF_W{1'b0}}, y32};
endmodule

// File: rtl/sha2_sched_step.sv
module sha2_sched_step
  import sha2_sched_pkg::*;
(
  input  logic              is64_i,
  input  logic [LANE_W-1:0] w_t2_i,
  input  logic [LANE_W-1:0] w_t7_i,
  input  logic [LANE_W-1:0] w_t15_i,
  input  logic [LANE_W-1:0] w_t16_i,
  output logic [LANE_W-1:0] w_o
);
  logic [LANE_W-1:0] s1, s0, sum;

  sha2_sigma #(.SMALL1(1'b1)) u_s1 (.is64_i(is64_i), .x_i(w_t2_i),  .y_o(s1));
  sha2_sigma #(.SMALL1(1'b0)) u_s0 (.is64_i(is64_i), .x_i(w_t15_i), .y_o(s0));

  assign sum = s1 + w_t7_i + s0 + w_t16_i;
  // 32-bit mode: drop carries past bit 31
  assign w_o = is64_i ? sum : {{HALF_W{1'b0}}, sum[HALF_W-1:0]};
endmodule

// File: rtl/sha2_sched_expand.sv
module sha2_sched_expand
  import sha2_sched_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       sew_i,
  input  logic [GRP_W-1:0] grp_a_i,
  input  logic [GRP_W-1:0] grp_b_i,
  input  logic [GRP_W-1:0] grp_c_i,
  output logic             valid_o,
  output logic             err_o,
  output logic [GRP_W-1:0] res_o
);
  logic is64, legal;
  logic [LANE_W-1:0] wa [NSLOT];
  logic [LANE_W-1:0] wb [NSLOT];
  logic [LANE_W-1:0] wc [NSLOT];
  logic [NSLOT-1:0][LANE_W-1:0] nw;
  logic [GRP_W-1:0] res_d;
  logic valid_q, err_q;
  logic [GRP_W-1:0] res_q;

  assign is64  = (sew_i == SEW_64);
  assign legal = is64 || (sew_i == SEW_32);

  function automatic logic [LANE_W-1:0] slot_of(input logic [GRP_W-1:0] g,
                                                input int k, input logic wide);
    return wide ? g[LANE_W*k +: LANE_W] : {{HALF_W{1'b0}}, g[HALF_W*k +: HALF_W]};
  endfunction

  // slot k: A -> W(k); B -> W4,W9,W10,W11; C -> W12,W13,W14,W15
  for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
    assign wa[k] = slot_of(grp_a_i, k, is64);
    assign wb[k] = slot_of(grp_b_i, k, is64);
    assign wc[k] = slot_of(grp_c_i, k, is64);
  end

  // new word 16+i: t-16 = W(i), t-15 = W(i+1) (W4 for i=3),
  // t-7 = W(9+i) (W12 for i=3), t-2 = W14/W15 or freshly made W16/W17
  for (genvar i = 0; i < NSLOT; i++) begin : g_step
    logic [LANE_W-1:0] t2, t7, t15, w_new;
    if (i < 2) begin : g_t2_in
      assign t2 = wc[i+2];
    end else begin : g_t2_chain
      assign t2 = g_step[i-2].w_new;
    end
    if (i < 3) begin : g_mid
      assign t15 = wa[i+1];
      assign t7  = wb[i+1];
    end else begin : g_last
      assign t15 = wb[0];
      assign t7  = wc[0];
    end
    sha2_sched_step u_step (
      .is64_i (is64),
      .w_t2_i (t2),
      .w_t7_i (t7),
      .w_t15_i(t15),
      .w_t16_i(wa[i]),
      .w_o    (w_new)
    );
    assign nw[i] = w_new;
  end

  always_comb begin
    res_d = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (is64) res_d[LANE_W*k +: LANE_W] = nw[k];
      else      res_d[HALF_W*k +: HALF_W] = nw[k][HALF_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i && legal;
      err_q   <= valid_i && !legal;
      if (valid_i && legal) res_q <= res_d;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign res_o   = res_q;
endmodule

// File: rtl/sha2_sched_chk.sv
module sha2_sched_chk
  import sha2_sched_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       sew_i,
  input logic             valid_o,
  input logic             err_o,
  input logic [GRP_W-1:0] res_o
);
  logic ok_sel;
  assign ok_sel = (sew_i == 2'd0) || (sew_i == 2'd1);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && !err_o && res_o == '0)); // R1

  AST_ILLEGAL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ok_sel |=> err_o && !valid_o); // R2

  AST_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ok_sel |=> $stable(res_o)); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sew_i == 2'd0 |=> res_o[GRP_W-1:GRP_W/2] == '0); // R9

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ok_sel |=> valid_o && !err_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !err_o && $stable(res_o)); // R10

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o)); // R10
endmodule

bind sha2_sched_expand sha2_sched_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sew_i  (sew_i),
  .valid_o(valid_o),
  .err_o  (err_o),
  .res_o  (res_o)
);

// File: tb/sim_sha2_sched_expand.sv
`timescale 1ns/1ps
module sim_sha2_sched_expand;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] sew_i = 2'd0;
  logic [255:0] grp_a_i = '0, grp_b_i = '0, grp_c_i = '0;
  logic valid_o, err_o;
  logic [255:0] res_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i; // 50 MHz

  sha2_sched_expand u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sew_i(sew_i),
    .grp_a_i(grp_a_i), .grp_b_i(grp_b_i), .grp_c_i(grp_c_i),
    .valid_o(valid_o), .err_o(err_o), .res_o(res_o)
  );

  function automatic logic [63:0] rot(input logic [63:0] x, input int n, input bit wide);
    logic [31:0] x32;
    if (wide) return (x >> n) | (x << (64 - n));
    x32 = x[31:0];
    return {32'h0, (x32 >> n) | (x32 << (32 - n))};
  endfunction

  function automatic logic [63:0] sg0(input logic [63:0] x, input bit wide);
    if (wide) return rot(x, 1, 1) ^ rot(x, 8, 1) ^ (x >> 7);
    return rot(x, 7, 0) ^ rot(x, 18, 0) ^ {32'h0, x[31:0] >> 3};
  endfunction

  function automatic logic [63:0] sg1(input logic [63:0] x, input bit wide);
    if (wide) return rot(x, 19, 1) ^ rot(x, 61, 1) ^ (x >> 6);
    return rot(x, 17, 0) ^ rot(x, 19, 0) ^ {32'h0, x[31:0] >> 10};
  endfunction

  // behavioural reference: full schedule array, W[t] for t = 16..19
  function automatic logic [255:0] ref_expand(input bit wide, input logic [255:0] a, b, c);
    logic [63:0] w [20];
    logic [63:0] mask;
    logic [255:0] r;
    int sh;
    int bmap [4];
    int cmap [4];
    bmap[0] = 4;  bmap[1] = 9;  bmap[2] = 10; bmap[3] = 11;
    cmap[0] = 12; cmap[1] = 13; cmap[2] = 14; cmap[3] = 15;
    sh = wide ? 64 : 32;
    mask = wide ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      w[k]       = 64'(a >> (sh * k)) & mask;
      w[bmap[k]] = 64'(b >> (sh * k)) & mask;
      w[cmap[k]] = 64'(c >> (sh * k)) & mask;
    end
    for (int i = 5; i < 9; i++) w[i] = '0;
    for (int t = 16; t < 20; t++)
      w[t] = (sg1(w[t-2], wide) + w[t-7] + sg0(w[t-15], wide) + w[t-16]) & mask;
    r = '0;
    for (int k = 0; k < 4; k++) r = r | (256'(w[16+k]) << (sh * k));
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  // cycle model
  logic exp_v, exp_e;
  logic [255:0] exp_r;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_v <= 1'b0; exp_e <= 1'b0; exp_r <= '0;
    end else begin
      exp_v <= valid_i && (sew_i < 2);
      exp_e <= valid_i && (sew_i >= 2);
      if (valid_i && sew_i < 2) exp_r <= ref_expand(sew_i == 2'd1, grp_a_i, grp_b_i, grp_c_i);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(valid_o === exp_v, cur_req, "valid_o", 256'(valid_o), 256'(exp_v));
      chk(err_o === exp_e, cur_req, "err_o", 256'(err_o), 256'(exp_e));
      chk(res_o === exp_r, cur_req, "res_o", res_o, exp_r);
    end
  end

  task automatic drive(input bit v, input logic [1:0] s,
                       input logic [255:0] a, b, c);
    @(negedge clk_i);
    valid_i = v; sew_i = s; grp_a_i = a; grp_b_i = b; grp_c_i = c;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    logic [255:0] a, b, c, first;
    // R1: reset state
    @(negedge clk_i);
    chk(valid_o === 1'b0 && err_o === 1'b0, "R1", "flags in reset",
        256'({valid_o, err_o}), 256'(0));
    chk(res_o === '0, "R1", "res in reset", res_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R5, R7, R8, R3: random 32-bit operations, back to back
    cur_req = "R5";
    for (int n = 0; n < 40; n++) drive(1, 2'd0, rnd256(), rnd256(), rnd256());
    // R6, R7, R8, R3: random 64-bit operations, with gaps
    cur_req = "R6";
    for (int n = 0; n < 40; n++) begin
      drive(1, 2'd1, rnd256(), rnd256(), rnd256());
      if (n % 5 == 0) drive(0, 2'd1, rnd256(), rnd256(), rnd256());
    end
    // R7: chain stressed with all-ones operands
    cur_req = "R7";
    drive(1, 2'd0, '1, '1, '1);
    drive(1, 2'd1, '1, '1, '1);

    // R4: changing W13 alone leaves res_o unchanged
    cur_req = "R4";
    for (int m = 0; m < 2; m++) begin
      a = rnd256(); b = rnd256(); c = rnd256();
      drive(1, 2'(m), a, b, c);
      drive(0, 2'(m), a, b, c);
      @(negedge clk_i); first = res_o;
      if (m == 0) c[63:32] = ~c[63:32]; else c[127:64] = ~c[127:64];
      drive(1, 2'(m), a, b, c);
      drive(0, 2'(m), a, b, c);
      @(negedge clk_i);
      chk(res_o === first, "R4", "W13 changed", res_o, first);
    end

    // R9: upper input bits ignored in 32-bit mode
    cur_req = "R9";
    a = rnd256(); b = rnd256(); c = rnd256();
    drive(1, 2'd0, a, b, c);
    drive(0, 2'd0, a, b, c);
    @(negedge clk_i); first = res_o;
    chk(res_o[255:128] === '0, "R9", "upper result half", res_o, first & {128'h0, {128{1'b1}}});
    drive(1, 2'd0, {~a[255:128], a[127:0]}, {~b[255:128], b[127:0]}, {~c[255:128], c[127:0]});
    drive(0, 2'd0, a, b, c);
    @(negedge clk_i);
    chk(res_o === first, "R9", "upper inputs changed", res_o, first);

    // R2: illegal selects raise err_o, hold res_o
    cur_req = "R2";
    first = res_o;
    drive(1, 2'd2, rnd256(), rnd256(), rnd256());
    drive(1, 2'd3, rnd256(), rnd256(), rnd256());
    drive(0, 2'd0, '0, '0, '0);
    @(negedge clk_i);
    chk(res_o === first, "R2", "held after illegal", res_o, first);

    // R10: idle cycles with moving operands keep outputs quiet and held
    cur_req = "R10";
    for (int n = 0; n < 6; n++) drive(0, 2'(n % 2), rnd256(), rnd256(), rnd256());
    drive(1, 2'd1, rnd256(), rnd256(), rnd256());
    drive(0, 2'd0, '0, '0, '0);
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule